// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Controller

This block steers a tapped oscillator so that its frequency settles at a programmed multiple of a slow reference clock. It runs entirely in the oscillator clock domain. The reference is brought in through a two-flop synchronizer, and its rising edges are detected after that. Between two detected edges a counter tallies oscillator cycles. The captured tally is compared with the target `(N+1) << div_sel`.

A ten-bit control word `{tap, mod_cnt}` is nudged by one step per reference period: up when the oscillator was slow, down when it was fast. Because the fine modulation count occupies the low bits, the loop walks through the fraction before carrying into the coarse tap. A freeze input holds the word and lets software-free logic overwrite the modulation field directly. An output clock is taken either straight from the oscillator or after a power-of-two post-divide. A lock flag reports a run of exact matches.

Top module: `fll_ctrl`

## Requirements
- R1: After reset the word is tap = 16, mod_cnt = 0, and locked is 0.
- R2: The target is (mult_n+1) × 2^div_sel oscillator cycles. The measured count is the number of oscillator cycles between two consecutive rising edges of the synchronized reference. When the count is below the target, the 10-bit word {tap, mod_cnt} rises by exactly one per reference period. The period that ends at the first reference edge after reset is not evaluated.
- R3: When the measured count is above the target, the word falls by exactly one per reference period.
- R4: When the measured count equals the target, the word keeps its value.
- R5: The word saturates at 0 when stepping down and at 1023 when stepping up. It never wraps.
- R6: An increment from mod_cnt = 31 clears mod_cnt and raises tap by one.
- R7: While freeze is 1, the word does not follow measurements. A mod_wr_en pulse replaces mod_cnt with mod_wr_data and leaves tap unchanged. A mod_wr_en pulse while freeze is 0 has no effect.
- R8: locked becomes 1 once 4 consecutive evaluated periods have matched the target. It returns to 0 after the first evaluated period that does not match.
- R9: With post_div_en = 1, clk_out is the oscillator divided by 2^div_sel (div_sel = 0 passes the oscillator through). With post_div_en = 0, clk_out is the oscillator itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; clocks all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous |
| mult_n | input | 7 | Multiplier field N |
| div_sel | input | 2 | Divider exponent; D = 2^div_sel |
| post_div_en | input | 1 | 1: clk_out = oscillator / D |
| freeze | input | 1 | Holds the control word |
| mod_wr_en | input | 1 | Write strobe for the modulation field under freeze |
| mod_wr_data | input | 5 | Value written to the modulation field |
| tap | output | 5 | Coarse tap code |
| mod_cnt | output | 5 | Fine modulation count |
| locked | output | 1 | Run of matching periods seen |
| clk_out | output | 1 | Output clock |

## Verification
A corrupted captured count, or a wrong target, shows up on `tap`/`mod_cnt` within about four oscillator cycles of the next synchronized reference edge. In that case the word moves the wrong way, or moves when it should stay still. A lock counter that is stuck or mis-cleared shows on `locked` at the end of the fourth matching period, or of the first mismatching one. A divider fault appears as a wrong edge count on `clk_out` within one 64-cycle window. The sweep covers every divider setting with several multipliers and counts below, equal to and above the target. It drives both saturation ends, the fraction-to-tap carry, and the freeze/write paths.

// File: rtl/fll_ctrl_pkg.sv
package fll_ctrl_pkg;

   typedef enum logic [1:0] {
      CMP_MATCH = 2'd0,
      CMP_SLOW  = 2'd1,
      CMP_FAST  = 2'd2
   } cmp_e;

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
   parameter int STAGES = 2
) (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic ref_clk,
   output logic ref_rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fll_ref_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], ref_clk};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign ref_rise = sync_q[STAGES-1] & ~last_q;

   // R2: a detected edge is a single-cycle event
   a_r2_edge_single: assert property (@(posedge osc_clk) disable iff (!rst_n)
      ref_rise |=> !ref_rise);

endmodule

// File: rtl/fll_period_counter.sv
module fll_period_counter #(
   parameter int CNT_W = 12
) (
   input  logic             osc_clk,
   input  logic             rst_n,
   input  logic             ref_rise,
   output logic [CNT_W-1:0] meas,
   output logic             meas_vld
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [CNT_W-1:0] run_q;
   logic             primed_q;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= '0;
         primed_q <= 1'b0;
         meas     <= '0;
         meas_vld <= 1'b0;
      end else begin
         meas_vld <= ref_rise & primed_q;
         if (ref_rise) begin
            meas     <= run_q;
            run_q    <= CNT_W'(1);
            primed_q <= 1'b1;
         end else if (run_q != CNT_TOP) begin
            run_q <= run_q + CNT_W'(1);
         end
      end
   end

   // R2: a measurement is only delivered right after an edge
   a_r2_vld_after_edge: assert property (@(posedge osc_clk) disable iff (!rst_n)
      meas_vld |-> $past(ref_rise));

   // R2: once running, a full period is never measured as zero cycles
   a_r2_meas_nonzero: assert property (@(posedge osc_clk) disable iff (!rst_n)
      meas_vld |-> (meas != '0));

endmodule

// File: rtl/fll_word_ctrl.sv
module fll_word_ctrl
   import fll_ctrl_pkg::*;
#(
   parameter int TAP_W        = 5,
   parameter int MOD_W        = 5,
   parameter int CNT_W        = 12,
   parameter int LOCK_PERIODS = 4,
   parameter int TAP_RST      = 16
) (
   input  logic                   osc_clk,
   input  logic                   rst_n,
   input  logic [CNT_W-1:0]       meas,
   input  logic                   meas_vld,
   input  logic [CNT_W-1:0]       target,
   input  logic                   freeze,
   input  logic                   mod_wr_en,
   input  logic [MOD_W-1:0]       mod_wr_data,
   output logic [TAP_W+MOD_W-1:0] word,
   output logic                   locked
);

   localparam int WORD_W = TAP_W + MOD_W;
   localparam int LOCK_W = $clog2(LOCK_PERIODS + 1);
   localparam logic [WORD_W-1:0] WORD_TOP  = '1;
   localparam logic [WORD_W-1:0] WORD_INIT = WORD_W'(TAP_RST) << MOD_W;
   localparam logic [LOCK_W-1:0] LOCK_FULL = LOCK_W'(LOCK_PERIODS);

   generate
      if (TAP_RST >= (1 << TAP_W)) begin : g_bad_rst
         $error("fll_word_ctrl: TAP_RST does not fit TAP_W");
      end
      if (LOCK_PERIODS < 1) begin : g_bad_lock
         $error("fll_word_ctrl: LOCK_PERIODS must be positive");
      end
   endgenerate

   cmp_e             verdict;
   logic [LOCK_W-1:0] run_match_q;

   always_comb begin
      if (meas < target)      verdict = CMP_SLOW;
      else if (meas > target) verdict = CMP_FAST;
      else                    verdict = CMP_MATCH;
   end

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= WORD_INIT;
      end else if (freeze) begin
         if (mod_wr_en) word[MOD_W-1:0] <= mod_wr_data;
      end else if (meas_vld) begin
         unique case (verdict)
            CMP_SLOW: if (word != WORD_TOP) word <= word + WORD_W'(1);
            CMP_FAST: if (word != '0)       word <= word - WORD_W'(1);
            default:  word <= word;
         endcase
      end
   end

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         run_match_q <= '0;
      end else if (meas_vld) begin
         if (verdict != CMP_MATCH)          run_match_q <= '0;
         else if (run_match_q != LOCK_FULL) run_match_q <= run_match_q + LOCK_W'(1);
      end
   end

   assign locked = (run_match_q == LOCK_FULL);

   // R7: frozen word holds without a write strobe
   a_r7_freeze_hold: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (freeze && !mod_wr_en) |=> $stable(word));

   // R7: a modulation write never touches the tap field
   a_r7_tap_untouched: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (freeze && mod_wr_en) |=> $stable(word[WORD_W-1:MOD_W]));

   // R4: a matching period leaves the word alone
   a_r4_match_hold: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (!freeze && meas_vld && meas == target) |=> $stable(word));

   // R5: a measurement moves the word by at most one step
   a_r5_single_step: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (!freeze && meas_vld) |=> (word == $past(word) || word == $past(word) + WORD_W'(1)
                                 || word == $past(word) - WORD_W'(1)));

   // R5: the top value never wraps to zero
   a_r5_no_wrap_top: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (!freeze && meas_vld && word == WORD_TOP) |=> (word != '0));

   // R8: lock is only gained on a matching measurement
   a_r8_lock_on_match: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $rose(locked) |-> $past(meas_vld && meas == target));

endmodule

// File: rtl/fll_clk_div.sv
module fll_clk_div #(
   parameter int DSEL_W = 2
) (
   input  logic              osc_clk,
   input  logic              rst_n,
   input  logic [DSEL_W-1:0] div_sel,
   input  logic              post_div_en,
   output logic              clk_out
);

   localparam int DIV_BITS = (1 << DSEL_W) - 1;

   generate
      if (DIV_BITS < 1 || DIV_BITS > 15) begin : g_bad_dsel
         $error("fll_clk_div: DSEL_W out of range");
      end
   endgenerate

   logic [DIV_BITS-1:0] div_q;
   logic                picked;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + DIV_BITS'(1);
   end

   always_comb begin
      picked = osc_clk;
      for (int k = 1; k <= DIV_BITS; k++) begin
         if (32'(div_sel) == k) picked = div_q[k-1];
      end
      clk_out = post_div_en ? picked : osc_clk;
   end

endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
   import fll_ctrl_pkg::*;
#(
   parameter int N_W          = 7,
   parameter int DSEL_W       = 2,
   parameter int TAP_W        = 5,
   parameter int MOD_W        = 5,
   parameter int CNT_W        = 12,
   parameter int SYNC_STAGES  = 2,
   parameter int LOCK_PERIODS = 4,
   parameter int TAP_RST      = 16
) (
   input  logic              osc_clk,
   input  logic              rst_n,
   input  logic              ref_clk,
   input  logic [N_W-1:0]    mult_n,
   input  logic [DSEL_W-1:0] div_sel,
   input  logic              post_div_en,
   input  logic              freeze,
   input  logic              mod_wr_en,
   input  logic [MOD_W-1:0]  mod_wr_data,
   output logic [TAP_W-1:0]  tap,
   output logic [MOD_W-1:0]  mod_cnt,
   output logic              locked,
   output logic              clk_out
);

   localparam int WORD_W   = TAP_W + MOD_W;
   localparam int MAX_SHFT = (1 << DSEL_W) - 1;
   localparam int NEED_W   = N_W + MAX_SHFT + 1;

   generate
      if (CNT_W < NEED_W) begin : g_bad_cnt
         $error("fll_ctrl: CNT_W too narrow for the largest target");
      end
   endgenerate

   logic              ref_rise;
   logic [CNT_W-1:0]  meas;
   logic              meas_vld;
   logic [CNT_W-1:0]  target;
   logic [WORD_W-1:0] word;

   assign target = (CNT_W'(mult_n) + CNT_W'(1)) << div_sel;

   fll_ref_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .ref_clk (ref_clk),
      .ref_rise(ref_rise)
   );

   fll_period_counter #(.CNT_W(CNT_W)) cnt_i (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .ref_rise(ref_rise),
      .meas    (meas),
      .meas_vld(meas_vld)
   );

   fll_word_ctrl #(
      .TAP_W(TAP_W), .MOD_W(MOD_W), .CNT_W(CNT_W),
      .LOCK_PERIODS(LOCK_PERIODS), .TAP_RST(TAP_RST)
   ) word_i (
      .osc_clk    (osc_clk),
      .rst_n      (rst_n),
      .meas       (meas),
      .meas_vld   (meas_vld),
      .target     (target),
      .freeze     (freeze),
      .mod_wr_en  (mod_wr_en),
      .mod_wr_data(mod_wr_data),
      .word       (word),
      .locked     (locked)
   );

   fll_clk_div #(.DSEL_W(DSEL_W)) div_i (
      .osc_clk    (osc_clk),
      .rst_n      (rst_n),
      .div_sel    (div_sel),
      .post_div_en(post_div_en),
      .clk_out    (clk_out)
   );

   assign tap     = word[WORD_W-1:MOD_W];
   assign mod_cnt = word[MOD_W-1:0];

endmodule

// File: tb/fll_ctrl_tb_top.sv
module fll_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WORD_INIT  = 16 * 32;
   localparam int WORD_MAX   = 1023;

   logic       osc_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_clk = 1'b0;
   logic [6:0] mult_n = '0;
   logic [1:0] div_sel = '0;
   logic       post_div_en = 1'b0;
   logic       freeze = 1'b0;
   logic       mod_wr_en = 1'b0;
   logic [4:0] mod_wr_data = '0;
   logic [4:0] tap;
   logic [4:0] mod_cnt;
   logic       locked;
   logic       clk_out;

   int errors = 0;
   int checks = 0;
   int edge_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
   always @(posedge clk_out) edge_cnt = edge_cnt + 1;

   fll_ctrl dut_i (
      .osc_clk(osc_clk), .rst_n(rst_n), .ref_clk(ref_clk),
      .mult_n(mult_n), .div_sel(div_sel), .post_div_en(post_div_en),
      .freeze(freeze), .mod_wr_en(mod_wr_en), .mod_wr_data(mod_wr_data),
      .tap(tap), .mod_cnt(mod_cnt), .locked(locked), .clk_out(clk_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int word_now();
      return int'(tap) * 32 + int'(mod_cnt);
   endfunction

   function automatic int clamp(input int v);
      if (v < 0) return 0;
      if (v > WORD_MAX) return WORD_MAX;
      return v;
   endfunction

   task automatic do_reset();
      ref_clk = 1'b0;
      rst_n = 1'b0;
      repeat (4) @(negedge osc_clk);
      rst_n = 1'b1;
      @(negedge osc_clk);
   endtask

   task automatic run_periods(input int m, input int e);
      for (int i = 0; i < e; i++) begin
         ref_clk = 1'b1;
         repeat (m / 2) @(negedge osc_clk);
         ref_clk = 1'b0;
         repeat (m - m / 2) @(negedge osc_clk);
      end
   endtask

   task automatic sweep_one(input int n, input int ds, input int m);
      int t;
      int dir;
      t = (n + 1) << ds;
      dir = (m < t) ? 1 : ((m > t) ? -1 : 0);
      mult_n = 7'(n);
      div_sel = 2'(ds);
      do_reset();
      run_periods(m, 6);
      if (dir > 0)      check("R2 step up", word_now(), clamp(WORD_INIT + 5));
      else if (dir < 0) check("R3 step down", word_now(), clamp(WORD_INIT - 5));
      else              check("R4 hold on match", word_now(), WORD_INIT);
      check("R8 lock after run", int'(locked), (dir == 0) ? 1 : 0);
   endtask

   initial begin
      repeat (190000) @(posedge osc_clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 tap reset", int'(tap), 16);
      check("R1 mod reset", int'(mod_cnt), 0);
      check("R1 locked reset", int'(locked), 0);

      // R2 R3 R4 R8 sweep over every divider and several multipliers
      for (int ds = 0; ds < 4; ds++) begin
         for (int ni = 0; ni < 3; ni++) begin
            int n;
            int t;
            n = (ni == 0) ? 3 : ((ni == 1) ? 9 : 20);
            t = (n + 1) << ds;
            if (t >= 10) sweep_one(n, ds, t);
            sweep_one(n, ds, (t + 2 < 10) ? 10 : t + 2);
            if (t - 2 >= 10) sweep_one(n, ds, t - 2);
         end
      end

      // R8 lock timing and clearing; T = 40
      mult_n = 7'd9; div_sel = 2'd2;
      do_reset();
      run_periods(40, 4);
      check("R8 not locked after 3 matches", int'(locked), 0);
      run_periods(40, 2);
      check("R8 locked after 5 matches", int'(locked), 1);
      run_periods(41, 1);
      run_periods(40, 1);
      check("R8 cleared on mismatch", int'(locked), 0);
      check("R3 one step after mismatch", word_now(), WORD_INIT - 1);

      // R7 write ignored when not frozen (count matches, word idle)
      mod_wr_data = 5'd7;
      mod_wr_en = 1'b1;
      @(negedge osc_clk);
      mod_wr_en = 1'b0;
      @(negedge osc_clk);
      check("R7 write ignored unfrozen", word_now(), WORD_INIT - 1);

      // R7 freeze holds against a slow count, R6 carry after write
      do_reset();
      freeze = 1'b1;
      run_periods(30, 6);
      check("R7 frozen word holds", word_now(), WORD_INIT);
      mod_wr_data = 5'd31;
      mod_wr_en = 1'b1;
      @(negedge osc_clk);
      mod_wr_en = 1'b0;
      @(negedge osc_clk);
      check("R7 mod written", int'(mod_cnt), 31);
      check("R7 tap kept", int'(tap), 16);
      freeze = 1'b0;
      run_periods(30, 2);
      check("R6 carry tap", int'(tap), 17);
      check("R6 carry mod", int'(mod_cnt), 1);

      // R5 saturation at the bottom: T = 1
      mult_n = 7'd0; div_sel = 2'd0;
      do_reset();
      run_periods(10, 520);
      check("R5 floor", word_now(), 0);

      // R5 saturation at the top: T = 1024
      mult_n = 7'd127; div_sel = 2'd3;
      do_reset();
      run_periods(10, 520);
      check("R5 ceiling", word_now(), WORD_MAX);

      // R9 output clock, 64-cycle windows
      for (int ds = 0; ds < 4; ds++) begin
         for (int pd = 0; pd < 2; pd++) begin
            div_sel = 2'(ds);
            post_div_en = pd[0];
            do_reset();
            repeat (2) @(negedge osc_clk);
            edge_cnt = 0;
            repeat (64) @(negedge osc_clk);
            check("R9 clk_out edges", edge_cnt, (pd == 1) ? (64 >> ds) : 64);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule